// File: doc/BRIEF.md
# Guaranteed-hit filter instruction cache

This block is a very small direct-mapped instruction store that sits in front of a larger first-level instruction cache. It never guesses. An instruction is supplied from the small store only when link metadata, gathered while earlier fetches ran, proves that the instruction is resident. A hit therefore needs no tag compare and carries no miss penalty. When residency cannot be proven, the fetch is served by the first-level cache in the same cycle. Meanwhile the small store compares the short line identifier held at the indexed slot. A match is a false miss and leaves the slot untouched. A mismatch is a true miss and replaces the slot with the line that the first-level cache returns.

Two kinds of link carry the proof. Each line has a next-line link, which says that the following slot (modulo the line count) holds the next line in memory. Each instruction has a target link, which says that the line its taken transfer lands on is resident. Every line also keeps a vector of the lines whose target links point into it. When the line is replaced, exactly those links are withdrawn. A single registered bit chooses the source of the next fetch. A record of the previous fetch lets the links be formed when the next fetch arrives from the first-level cache. The fetch stage must present the next address as previous plus one after a sequential fetch. After a taken fetch it must present the same target that instruction has always used.

Top module: `gh_fetch_filter`

## Requirements
- R1: After reset no line is resident and no link is set. The first fetch after reset is served by the first-level cache (`from_small` = 0) and reports `line_present` = 0.
- R2: A sequential fetch (`fetch_taken` = 0) of a word other than the last in its line makes the next fetch come from the small store (`from_small` = 1).
- R3: A sequential fetch of the last word of a line (word offset all ones) makes the next fetch come from the small store if and only if that line's next-line link is set.
- R4: A fetch served by the first-level cache sets the next-line link of the previous fetch's line when that previous fetch was sequential, was of the last word of its line, and the current fetch is in the next memory line. This applies to both true and false misses.
- R5: A taken fetch makes the next fetch come from the small store if and only if that instruction's target link is set. A fetch served by the first-level cache that directly follows a taken fetch sets that instruction's target link. The exception is a true miss that replaced the transferring instruction's own line.
- R6: When `from_small` = 1, `small_word` equals the instruction word at `fetch_addr`, as written by the most recent fill of that slot.
- R7: When `from_small` = 0, `line_present` is 1 exactly when the indexed slot is valid and its identifier (the address bits above index and offset) equals that of `fetch_addr`. A false miss leaves the slot's contents and links unchanged.
- R8: A true miss at slot k clears slot k's next-line and target links and the next-line link of slot k-1 (modulo the line count). It also clears every target link of each line that held a target link into slot k.
- R9: While `fetch_valid` = 0, no state changes and `from_small` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_addr | input | ADDR_W | Word address of the fetched instruction |
| fetch_taken | input | 1 | Fetched instruction is a predicted-taken transfer |
| l1_line | input | WORDS*DATA_W | Line returned by the first-level cache for fetch_addr, word 0 in the low bits |
| from_small | output | 1 | Current fetch is served by the small store |
| small_word | output | DATA_W | Instruction word read from the small store |
| line_present | output | 1 | Identifier check result on a first-level-served fetch |

## Verification
The bench builds the block with its defaults: 16 lines of 4 words, 12-bit word addresses, and therefore a 6-bit line identifier. At this size a loop of 24 lines exceeds capacity by half. Lines 16 apart alias onto one slot, so conflict replacement and replacement of a branch's own line can both be reached in a few dozen fetches. A random walk over 64 lines with static branch targets then sweeps thousands of link formations and invalidations. The bench compares these against an independent model that records each target link by its destination slot rather than through per-line vectors.

// File: rtl/gh_pkg.sv
package gh_pkg;
  localparam int GH_LINES  = 16;
  localparam int GH_WORDS  = 4;
  localparam int GH_ADDR_W = 12;
  localparam int GH_DATA_W = 32;

  typedef enum logic {
    SRC_L1    = 1'b0,
    SRC_SMALL = 1'b1
  } fetch_src_e;
endpackage

// File: rtl/gh_data.sv
module gh_data #(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_word
);
  logic [LINE_W-1:0] store_q [LINES];
  logic [LINE_W-1:0] sel_line;

  // instruction words carry no reset; residency is governed by the metadata
  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[wr_idx] <= wr_line;
    end
  end

  always_comb begin
    sel_line = store_q[rd_idx];
    rd_word  = sel_line[int'(rd_off) * DATA_W +: DATA_W];
  end
endmodule

// File: rtl/gh_meta.sv
module gh_meta #(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int ID_W  = 6,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [ID_W-1:0]  fill_id,
  input  logic             ns_set_en,
  input  logic [IDX_W-1:0] ns_set_idx,
  input  logic             nt_set_en,
  input  logic [IDX_W-1:0] nt_src_idx,
  input  logic [OFF_W-1:0] nt_src_off,
  input  logic [IDX_W-1:0] nt_tgt_idx,
  input  logic [IDX_W-1:0] q_idx,
  input  logic [OFF_W-1:0] q_off,
  input  logic [ID_W-1:0]  q_id,
  output logic             resident,
  output logic             ns_cur,
  output logic             nt_cur
);
  logic [LINES-1:0]             valid_v;
  logic [LINES-1:0]             ns_v;
  logic [LINES-1:0][WORDS-1:0]  nt_v;
  logic [LINES-1:0][LINES-1:0]  tl_v;
  logic [LINES-1:0][ID_W-1:0]   id_v;
  logic [LINES-1:0]             kill_mask;
  logic [IDX_W-1:0]             fill_prev;

  // lines whose target links must go when a slot is refilled: the slot itself
  // and every line recorded as linking into it
  always_comb begin
    fill_prev = fill_idx - 1'b1;
    kill_mask = '0;
    if (fill_en) begin
      kill_mask = tl_v[fill_idx] | (LINES'(1) << fill_idx);
    end
  end

  for (genvar j = 0; j < LINES; j++) begin : g_line
    logic             v_q, v_d;
    logic             ns_q, ns_d;
    logic [WORDS-1:0] nt_q, nt_d;
    logic [LINES-1:0] tl_q, tl_d;
    logic [ID_W-1:0]  id_q, id_d;

    always_comb begin
      v_d  = v_q;
      ns_d = ns_q;
      id_d = id_q;
      nt_d = kill_mask[j] ? '0 : nt_q;
      tl_d = tl_q & ~kill_mask;
      if (fill_en && fill_idx == IDX_W'(j)) begin
        v_d  = 1'b1;
        ns_d = 1'b0;
        tl_d = '0;
        id_d = fill_id;
      end
      if (fill_en && fill_prev == IDX_W'(j)) begin
        ns_d = 1'b0;
      end
      if (ns_set_en && ns_set_idx == IDX_W'(j)) begin
        ns_d = 1'b1;
      end
      if (nt_set_en && nt_src_idx == IDX_W'(j)) begin
        nt_d[nt_src_off] = 1'b1;
      end
      if (nt_set_en && nt_tgt_idx == IDX_W'(j)) begin
        tl_d[nt_src_idx] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q  <= 1'b0;
        ns_q <= 1'b0;
        nt_q <= '0;
        tl_q <= '0;
        id_q <= '0;
      end else begin
        v_q  <= v_d;
        ns_q <= ns_d;
        nt_q <= nt_d;
        tl_q <= tl_d;
        id_q <= id_d;
      end
    end

    assign valid_v[j] = v_q;
    assign ns_v[j]    = ns_q;
    assign nt_v[j]    = nt_q;
    assign tl_v[j]    = tl_q;
    assign id_v[j]    = id_q;
  end

  assign resident = valid_v[q_idx] && (id_v[q_idx] == q_id);
  assign ns_cur   = ns_v[q_idx];
  assign nt_cur   = nt_v[q_idx][q_off];

  AST_FILL_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_v[$past(fill_idx)] && !ns_v[$past(fill_idx)] && (nt_v[$past(fill_idx)] == '0)); // R8

  AST_FILL_PRED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !(ns_set_en && ns_set_idx == fill_prev) |=> !ns_v[$past(fill_prev)]); // R8

  AST_FILL_ID_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> id_v[$past(fill_idx)] == $past(fill_id)); // R7
endmodule

// File: rtl/gh_decide.sv
module gh_decide
  import gh_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int OFF_W   = 2,
  parameter int LADDR_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_valid,
  input  logic               fetch_taken,
  input  logic [LADDR_W-1:0] fetch_line,
  input  logic [OFF_W-1:0]   fetch_off,
  input  logic               true_miss,
  input  logic               ns_cur,
  input  logic               nt_cur,
  output fetch_src_e         src_q,
  output logic               ns_set_en,
  output logic [IDX_W-1:0]   ns_set_idx,
  output logic               nt_set_en,
  output logic [IDX_W-1:0]   nt_src_idx,
  output logic [OFF_W-1:0]   nt_src_off
);
  fetch_src_e         src_d;
  logic               last_v_q, last_v_d;
  logic               last_tk_q, last_tk_d;
  logic [LADDR_W-1:0] last_line_q, last_line_d;
  logic [OFF_W-1:0]   last_off_q, last_off_d;
  logic               l1_fetch, self_link, nt_eff, ns_eff, go_small;

  always_comb begin
    l1_fetch   = fetch_valid && (src_q == SRC_L1);
    ns_set_idx = last_line_q[IDX_W-1:0];
    nt_src_idx = last_line_q[IDX_W-1:0];
    nt_src_off = last_off_q;
    ns_set_en  = l1_fetch && last_v_q && !last_tk_q && (&last_off_q) &&
                 (fetch_line == LADDR_W'(last_line_q + 1'b1));
    nt_set_en  = l1_fetch && last_v_q && last_tk_q &&
                 !(true_miss && (last_line_q[IDX_W-1:0] == fetch_line[IDX_W-1:0]));
    // a transfer to itself gains its link in the very cycle it is tested
    self_link  = nt_set_en && (last_line_q == fetch_line) && (last_off_q == fetch_off);
    nt_eff     = (nt_cur && !true_miss) || self_link;
    ns_eff     = ns_cur && !true_miss;
    go_small   = fetch_taken ? nt_eff : (!(&fetch_off) || ns_eff);
  end

  always_comb begin
    src_d       = src_q;
    last_v_d    = last_v_q;
    last_tk_d   = last_tk_q;
    last_line_d = last_line_q;
    last_off_d  = last_off_q;
    if (fetch_valid) begin
      src_d       = go_small ? SRC_SMALL : SRC_L1;
      last_v_d    = 1'b1;
      last_tk_d   = fetch_taken;
      last_line_d = fetch_line;
      last_off_d  = fetch_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q       <= SRC_L1;
      last_v_q    <= 1'b0;
      last_tk_q   <= 1'b0;
      last_line_q <= '0;
      last_off_q  <= '0;
    end else begin
      src_q       <= src_d;
      last_v_q    <= last_v_d;
      last_tk_q   <= last_tk_d;
      last_line_q <= last_line_d;
      last_off_q  <= last_off_d;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> $stable(src_q)); // R9

  AST_MIDLINE_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_taken && !(&fetch_off) |=> src_q == SRC_SMALL); // R2

  AST_LINE_END_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_taken && (&fetch_off) && !ns_cur |=> src_q == SRC_L1); // R3

  AST_TAKEN_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_taken && !nt_cur && !nt_set_en |=> src_q == SRC_L1); // R5
endmodule

// File: rtl/gh_fetch_filter.sv
module gh_fetch_filter
  import gh_pkg::*;
#(
  parameter int LINES  = GH_LINES,
  parameter int WORDS  = GH_WORDS,
  parameter int ADDR_W = GH_ADDR_W,
  parameter int DATA_W = GH_DATA_W,
  localparam int IDX_W   = $clog2(LINES),
  localparam int OFF_W   = $clog2(WORDS),
  localparam int ID_W    = ADDR_W - IDX_W - OFF_W,
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int LINE_W  = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_taken,
  input  logic [LINE_W-1:0] l1_line,
  output logic              from_small,
  output logic [DATA_W-1:0] small_word,
  output logic              line_present
);
  logic [OFF_W-1:0]   f_off;
  logic [LADDR_W-1:0] f_line;
  logic [IDX_W-1:0]   f_idx;
  logic [ID_W-1:0]    f_id;
  fetch_src_e         src;
  logic               resident, ns_cur, nt_cur, true_miss;
  logic               ns_set_en, nt_set_en;
  logic [IDX_W-1:0]   ns_set_idx, nt_src_idx;
  logic [OFF_W-1:0]   nt_src_off;

  assign f_off  = fetch_addr[OFF_W-1:0];
  assign f_line = fetch_addr[ADDR_W-1:OFF_W];
  assign f_idx  = f_line[IDX_W-1:0];
  assign f_id   = fetch_addr[ADDR_W-1 -: ID_W];

  assign from_small   = (src == SRC_SMALL);
  assign line_present = resident;
  assign true_miss    = fetch_valid && !from_small && !resident;

  gh_decide #(.IDX_W(IDX_W), .OFF_W(OFF_W), .LADDR_W(LADDR_W)) u_decide (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_taken (fetch_taken),
    .fetch_line  (f_line),
    .fetch_off   (f_off),
    .true_miss   (true_miss),
    .ns_cur      (ns_cur),
    .nt_cur      (nt_cur),
    .src_q       (src),
    .ns_set_en   (ns_set_en),
    .ns_set_idx  (ns_set_idx),
    .nt_set_en   (nt_set_en),
    .nt_src_idx  (nt_src_idx),
    .nt_src_off  (nt_src_off)
  );

  gh_meta #(.LINES(LINES), .WORDS(WORDS), .ID_W(ID_W)) u_meta (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (true_miss),
    .fill_idx   (f_idx),
    .fill_id    (f_id),
    .ns_set_en  (ns_set_en),
    .ns_set_idx (ns_set_idx),
    .nt_set_en  (nt_set_en),
    .nt_src_idx (nt_src_idx),
    .nt_src_off (nt_src_off),
    .nt_tgt_idx (f_idx),
    .q_idx      (f_idx),
    .q_off      (f_off),
    .q_id       (f_id),
    .resident   (resident),
    .ns_cur     (ns_cur),
    .nt_cur     (nt_cur)
  );

  gh_data #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .wr_en   (true_miss),
    .wr_idx  (f_idx),
    .wr_line (l1_line),
    .rd_idx  (f_idx),
    .rd_off  (f_off),
    .rd_word (small_word)
  );

  AST_HIT_PROVEN: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && from_small |-> resident); // R6

  AST_MISS_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    true_miss |=> $past(fetch_addr) != fetch_addr || !fetch_valid || from_small || resident); // R7
endmodule

// File: tb/sim_gh_fetch_filter.sv
module sim_gh_fetch_filter;
  localparam int LINES  = 16;
  localparam int WORDS  = 4;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 2;

  logic                    clk;
  logic                    rst_n;
  logic                    fetch_valid;
  logic [ADDR_W-1:0]       fetch_addr;
  logic                    fetch_taken;
  logic [WORDS*DATA_W-1:0] l1_line;
  logic                    from_small;
  logic [DATA_W-1:0]       small_word;
  logic                    line_present;

  int n_vec = 0;
  int n_bad = 0;

  // reference model: slots, next-line links, per-instruction target slots
  bit    m_v   [LINES];
  int    m_line[LINES];
  bit    m_ns  [LINES];
  bit    m_ntv [LINES][WORDS];
  int    m_ntt [LINES][WORDS];
  bit    m_lost[LINES];
  bit    m_dec;
  string m_why;
  bit    l_v, l_tk;
  int    l_line, l_off;
  bit    first_fetch;

  gh_fetch_filter u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .fetch_addr   (fetch_addr),
    .fetch_taken  (fetch_taken),
    .l1_line      (l1_line),
    .from_small   (from_small),
    .small_word   (small_word),
    .line_present (line_present)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  always_comb begin
    for (int w = 0; w < WORDS; w++) begin
      l1_line[w*DATA_W +: DATA_W] = mem_word({fetch_addr[ADDR_W-1:OFF_W], OFF_W'(w)});
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < LINES; s++) begin
      m_v[s] = 0; m_line[s] = 0; m_ns[s] = 0; m_lost[s] = 0;
      for (int w = 0; w < WORDS; w++) begin
        m_ntv[s][w] = 0; m_ntt[s][w] = 0;
      end
    end
    m_dec = 0; m_why = "R1"; l_v = 0; l_tk = 0; l_line = 0; l_off = 0;
    first_fetch = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fetch_valid = 1'b0; fetch_taken = 1'b0; fetch_addr = '0;
    repeat (2) @(negedge clk);
    chk(from_small == 1'b0, "R1", from_small, 0);
    rst_n = 1'b1;
    model_clear();
  endtask

  // replacement of slot k in the model (R8)
  task automatic model_evict(input int k, input int line);
    bit hit[LINES];
    for (int s = 0; s < LINES; s++) begin
      hit[s] = (s == k);
      for (int w = 0; w < WORDS; w++)
        if (m_ntv[s][w] && m_ntt[s][w] == k) hit[s] = 1;
    end
    for (int s = 0; s < LINES; s++) begin
      if (hit[s]) begin
        for (int w = 0; w < WORDS; w++) m_ntv[s][w] = 0;
        if (s != k) m_lost[s] = 1;
      end
    end
    if (m_ns[(k + LINES - 1) % LINES]) m_lost[(k + LINES - 1) % LINES] = 1;
    m_ns[(k + LINES - 1) % LINES] = 0;
    m_ns[k] = 0; m_lost[k] = 0;
    m_v[k] = 1; m_line[k] = line;
  endtask

  task automatic do_fetch(input int a, input bit tk);
    int  line, idx, off;
    bit  present, nxt;
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = ADDR_W'(a); fetch_taken = tk;
    #2;
    line = a / WORDS; idx = line % LINES; off = a % WORDS;
    chk(from_small == m_dec, m_why, from_small, m_dec);
    if (m_dec) begin
      chk(small_word == mem_word(ADDR_W'(a)), "R6", small_word, mem_word(ADDR_W'(a)));
    end else begin
      present = m_v[idx] && (m_line[idx] == line);
      chk(line_present == present, first_fetch ? "R1" : "R7", line_present, present);
      if (!present) model_evict(idx, line);
      if (l_v && !l_tk && l_off == WORDS - 1 && line == l_line + 1) begin
        m_ns[l_line % LINES] = 1; m_lost[l_line % LINES] = 0;
      end
      if (l_v && l_tk && !(!present && (l_line % LINES) == idx)) begin
        m_ntv[l_line % LINES][l_off] = 1;
        m_ntt[l_line % LINES][l_off] = idx;
        m_lost[l_line % LINES] = 0;
      end
    end
    first_fetch = 0;
    if (tk) begin
      nxt = m_ntv[idx][off];
      m_why = (!nxt && m_lost[idx]) ? "R8" : "R5";
    end else if (off != WORDS - 1) begin
      nxt = 1; m_why = "R2";
    end else begin
      nxt = m_ns[idx];
      m_why = nxt ? "R4" : (m_lost[idx] ? "R8" : "R3");
    end
    m_dec = nxt;
    l_v = 1; l_tk = tk; l_line = line; l_off = off;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fetch_valid = 1'b0; fetch_addr = ADDR_W'(4095); fetch_taken = 1'b1;
      #2;
      chk(from_small == m_dec, "R9", from_small, m_dec);
    end
  endtask

  task automatic loop(input int lo, input int hi, input int iters, input int gap);
    for (int it = 0; it < iters; it++) begin
      for (int a = lo; a <= hi; a++) begin
        do_fetch(a, (a == hi) && (it < iters - 1));
        if (gap > 0 && (a % 3) == 0) idle(gap);
      end
    end
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int a;
    bit br;
    rst_n = 1'b0; fetch_valid = 1'b0; fetch_taken = 1'b0; fetch_addr = '0;
    // small loop over five lines: links form, then steady hits
    do_reset();
    loop(8, 27, 6, 0);
    // loop wider than the store: capacity replacement withdraws links
    do_reset();
    loop(0, 95, 3, 0);
    // two lines aliasing one slot, each branching into the other
    do_reset();
    for (int it = 0; it < 4; it++) begin
      for (int x = 300; x <= 303; x++) do_fetch(x, x == 303);
      for (int x = 364; x <= 367; x++) do_fetch(x, x == 367);
    end
    // transfer to itself, then fall through
    do_reset();
    for (int it = 0; it < 5; it++) do_fetch(500, 1'b1);
    for (int x = 500; x <= 509; x++) do_fetch(x, 1'b0);
    // branch back into a resident line: false miss first time
    do_reset();
    for (int x = 600; x <= 610; x++) do_fetch(x, 1'b0);
    for (int it = 0; it < 3; it++) begin
      do_fetch(611, 1'b1);
      for (int x = 604; x <= 610; x++) do_fetch(x, 1'b0);
    end
    // idle cycles interleaved with fetches
    do_reset();
    loop(40, 51, 4, 2);
    // random walk over 64 lines with fixed per-address targets
    do_reset();
    lfsr = 16'hACE1;
    a = 0;
    for (int step = 0; step < 4000; step++) begin
      br = ((a % 5) == 2 && lfsr[0]) || (a == 255);
      do_fetch(a, br);
      if (lfsr[3]) idle(1);
      a = br ? ((a * 37 + 11) % 256) : a + 1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule